// File: doc/BRIEF.md
# Descriptor-Table Bus Master DMA Engine

This block moves sector data between a byte-wide storage device port and a 32-bit system memory port without processor help. Software places a table of eight-byte region descriptors in memory, loads the table's address into the pointer register, and selects the direction. It issues the device command and then sets the run bit. The engine reads each descriptor, moves that region one byte at a time, and continues to the next entry. It stops after the entry whose end flag is set.

The device signals the end of its work on its interrupt line. The engine latches that line into a status bit that software clears by writing a 1. If the line rises while bytes are still owed, the engine reports an error and halts. Writing a command byte whose run bit is 0 stops the engine at once.

Register map. A control dword is selected by `reg_sel` = 0 (byte offset 0). Lane 0 holds the command: bit 0 is run and bit 3 is direction (1 = device to memory). Lane 2 holds the status: bit 16 is busy, bit 17 is fault and bit 18 is device event. The pointer dword is selected by `reg_sel` = 1 (byte offset 4). `reg_be` picks the bytes that a write touches.

Top module: `bmdma_engine`

## Requirements
- R1: After reset both dwords read 0, and `mem_req` and `dev_ack` are low.
- R2: A pointer write updates only the lanes enabled in `reg_be`, and bits 1:0 of the pointer always read 0.
- R3: A write that moves the run bit (dword 0, bit 0) from 0 to 1 sets busy (bit 16) from the next cycle on. The first memory reads go to the pointer and then to pointer+4.
- R4: In device-to-memory mode, each byte acknowledged on the device port is written to memory in the order received, at the descriptor's buffer address plus its offset. The write uses the word-aligned address, a single byte enable (1 << addr[1:0]) and the byte on that lane.
- R5: In memory-to-device mode, each byte is first read from memory at its word address, and then presented on `dev_tx_data` while `dev_ack` is high.
- R6: A descriptor count field (second word, bits 15:0) of 0 moves exactly 65536 bytes.
- R7: If bit 31 of a descriptor's second word is clear, the next descriptor is fetched at that entry's address plus 8. When the byte count of the entry with bit 31 set is exhausted, busy clears and memory traffic stops.
- R8: Writing the command byte with run = 0 clears busy on the next cycle, and no memory or device transfer follows.
- R9: `dev_intrq` high in a cycle sets the event bit (bit 18) in the next cycle. Writing 1 to bit 18 or bit 17 clears that bit. When a set and a clear fall in the same cycle, the set wins.
- R10: `dev_intrq` high while busy sets the fault bit (bit 17) and clears busy in the next cycle.
- R11: The direction is captured when the run bit rises. A later command write that changes bit 3 while busy is visible on readback but does not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Dword select: 0 control/status, 1 table pointer |
| reg_be | input | 4 | Byte enables for a register write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected dword |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory accepts or completes the access this cycle |
| dev_req | input | 1 | Device ready to exchange one byte |
| dev_ack | output | 1 | Byte exchanged this cycle |
| dev_rx_data | input | 8 | Byte from the device |
| dev_tx_data | output | 8 | Byte to the device |
| dev_intrq | input | 1 | Device interrupt / completion line |

## Verification
Two events can land on the status register in the same cycle: the device raising its interrupt line, and software writing 1 to clear the event bit. The bench drives `dev_intrq` high during the very cycle its W1C write is on the port. It judges the result against a behavioural model of the event bit that is updated on every clock, which expects the bit to stay set. A second overlap is the interrupt line rising while bytes are still moving. In that case the bench expects the fault bit and the drop of busy to appear together, one cycle later.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LANES    = WORD_W / 8;
    localparam int unsigned LAST_BIT = 31;   // end flag in descriptor word 1
    localparam int unsigned RUN_BIT  = 0;
    localparam int unsigned DIR_BIT  = 3;
    localparam int unsigned BUSY_BIT = 16;
    localparam int unsigned FLT_BIT  = 17;
    localparam int unsigned EVT_BIT  = 18;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_BUF,
        ST_GET_LEN,
        ST_DEV,
        ST_MEM
    } eng_state_e;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [LANES-1:0]  reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              eng_active,
    input  logic              fault_evt,
    input  logic              dev_intrq,
    output logic              start_pls,
    output logic              stop_pls,
    output logic              dir_d2m,
    output logic [WORD_W-1:0] tbl_ptr,
    output logic              fault_st,
    output logic              event_st
);
    typedef struct packed {
        logic              run;
        logic              dir;
        logic [WORD_W-1:0] ptr;
        logic              fault;
        logic              evt;
    } regs_s;

    regs_s q, d;
    logic  ctl_wr, ptr_wr, clr_fault, clr_evt;

    always_comb begin
        d         = q;
        start_pls = 1'b0;
        stop_pls  = 1'b0;
        ctl_wr    = reg_wr && !reg_sel;
        ptr_wr    = reg_wr && reg_sel;
        clr_fault = ctl_wr && reg_be[2] && reg_wdata[FLT_BIT];
        clr_evt   = ctl_wr && reg_be[2] && reg_wdata[EVT_BIT];

        if (ctl_wr && reg_be[0]) begin
            d.run     = reg_wdata[RUN_BIT];
            d.dir     = reg_wdata[DIR_BIT];
            start_pls = reg_wdata[RUN_BIT] && !q.run;
            stop_pls  = !reg_wdata[RUN_BIT];
        end

        if (ptr_wr) begin
            for (int b = 0; b < int'(LANES); b++) begin
                if (reg_be[b]) d.ptr[8*b +: 8] = reg_wdata[8*b +: 8];
            end
        end
        d.ptr[1:0] = 2'b00;

        // a new event outranks a clear in the same cycle
        d.fault = fault_evt || (q.fault && !clr_fault);
        d.evt   = dev_intrq || (q.evt && !clr_evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata = q.ptr;
        end else begin
            reg_rdata[RUN_BIT]  = q.run;
            reg_rdata[DIR_BIT]  = q.dir;
            reg_rdata[BUSY_BIT] = eng_active;
            reg_rdata[FLT_BIT]  = q.fault;
            reg_rdata[EVT_BIT]  = q.evt;
        end
    end

    assign dir_d2m  = q.dir;
    assign tbl_ptr  = q.ptr;
    assign fault_st = q.fault;
    assign event_st = q.evt;
endmodule

// File: rtl/bmdma_core.sv
module bmdma_core
    import bmdma_pkg::*;
#(
    parameter int unsigned LEN_W = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pls,
    input  logic              stop_pls,
    input  logic              dir_d2m,
    input  logic [WORD_W-1:0] tbl_ptr,
    input  logic              dev_intrq,
    input  logic              dev_req,
    input  logic [7:0]        dev_rx_data,
    output logic              dev_ack,
    output logic [7:0]        dev_tx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              eng_active,
    output logic              fault_evt
);
    localparam int unsigned CNT_W  = LEN_W + 1;
    localparam int unsigned DESC_B = 8;

    typedef struct packed {
        eng_state_e        st;
        logic [WORD_W-1:0] ptr;
        logic [WORD_W-1:0] baddr;
        logic [CNT_W-1:0]  remain;
        logic              last;
        logic              d2m;
        logic [7:0]        data;
    } core_s;

    core_s q, d;
    logic  step_byte;
    logic  busy;

    always_comb begin
        d         = q;
        step_byte = 1'b0;
        dev_ack   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        busy      = (q.st != ST_IDLE);

        unique case (q.st)
            ST_IDLE: begin
                if (start_pls) begin
                    d.st  = ST_GET_BUF;
                    d.ptr = tbl_ptr;
                    d.d2m = dir_d2m;
                end
            end
            ST_GET_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr;
                mem_be   = '1;
                if (mem_ready) begin
                    d.baddr = mem_rdata;
                    d.st    = ST_GET_LEN;
                end
            end
            ST_GET_LEN: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + WORD_W'(4);
                mem_be   = '1;
                if (mem_ready) begin
                    if (mem_rdata[LEN_W-1:0] == '0)
                        d.remain = CNT_W'(1) << LEN_W;
                    else
                        d.remain = CNT_W'(mem_rdata[LEN_W-1:0]);
                    d.last = mem_rdata[LAST_BIT];
                    d.ptr  = q.ptr + WORD_W'(DESC_B);
                    d.st   = q.d2m ? ST_DEV : ST_MEM;
                end
            end
            ST_DEV: begin
                if (dev_req) begin
                    dev_ack = 1'b1;
                    if (q.d2m) begin
                        d.data = dev_rx_data;
                        d.st   = ST_MEM;
                    end else begin
                        step_byte = 1'b1;
                    end
                end
            end
            ST_MEM: begin
                mem_req  = 1'b1;
                mem_we   = q.d2m;
                mem_addr = {q.baddr[WORD_W-1:2], 2'b00};
                mem_be   = LANES'(1) << q.baddr[1:0];
                if (mem_ready) begin
                    if (q.d2m) begin
                        step_byte = 1'b1;
                    end else begin
                        d.data = mem_rdata[{q.baddr[1:0], 3'b000} +: 8];
                        d.st   = ST_DEV;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (step_byte) begin
            d.remain = q.remain - CNT_W'(1);
            d.baddr  = q.baddr + WORD_W'(1);
            if (q.remain == CNT_W'(1))
                d.st = q.last ? ST_IDLE : ST_GET_BUF;
            else
                d.st = q.d2m ? ST_DEV : ST_MEM;
        end

        fault_evt = busy && dev_intrq;
        if (stop_pls || fault_evt) d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign mem_wdata   = {LANES{q.data}};
    assign dev_tx_data = q.data;
    assign eng_active  = (q.st != ST_IDLE);
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
    import bmdma_pkg::*;
#(
    parameter int unsigned LEN_W = 16
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    input  logic        dev_req,
    output logic        dev_ack,
    input  logic [7:0]  dev_rx_data,
    output logic [7:0]  dev_tx_data,
    input  logic        dev_intrq
);
    logic              start_pls, stop_pls, dir_d2m;
    logic              eng_active, fault_evt, fault_st, event_st;
    logic [WORD_W-1:0] tbl_ptr;

    bmdma_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_be     (reg_be),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .eng_active (eng_active),
        .fault_evt  (fault_evt),
        .dev_intrq  (dev_intrq),
        .start_pls  (start_pls),
        .stop_pls   (stop_pls),
        .dir_d2m    (dir_d2m),
        .tbl_ptr    (tbl_ptr),
        .fault_st   (fault_st),
        .event_st   (event_st)
    );

    bmdma_core #(.LEN_W(LEN_W)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pls   (start_pls),
        .stop_pls    (stop_pls),
        .dir_d2m     (dir_d2m),
        .tbl_ptr     (tbl_ptr),
        .dev_intrq   (dev_intrq),
        .dev_req     (dev_req),
        .dev_rx_data (dev_rx_data),
        .dev_ack     (dev_ack),
        .dev_tx_data (dev_tx_data),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_be      (mem_be),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .eng_active  (eng_active),
        .fault_evt   (fault_evt)
    );
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_pls,
    input logic       stop_pls,
    input logic       eng_active,
    input logic       fault_st,
    input logic       event_st,
    input logic       dev_intrq,
    input logic       dev_req,
    input logic       dev_ack,
    input logic       mem_req,
    input logic       mem_we,
    input logic [3:0] mem_be
);
    // R3
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pls |=> eng_active);

    // R8
    idle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pls |=> !eng_active);

    // R9
    event_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_intrq |=> event_st);

    // R10
    early_end_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_intrq && eng_active) |=> (fault_st && !eng_active));

    // R7
    mem_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> eng_active);

    // R4
    single_lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1));

    // R5
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> (dev_req && eng_active));
endmodule

bind bmdma_engine bmdma_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_pls  (start_pls),
    .stop_pls   (stop_pls),
    .eng_active (eng_active),
    .fault_st   (fault_st),
    .event_st   (event_st),
    .dev_intrq  (dev_intrq),
    .dev_req    (dev_req),
    .dev_ack    (dev_ack),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be)
);

// File: tb/test_bmdma_engine.sv
`timescale 1ns/1ps
module test_bmdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        mem_ready;
    logic        dev_req = 1'b0;
    logic        dev_ack;
    logic [7:0]  dev_rx_data, dev_tx_data;
    logic        dev_intrq = 1'b0;

    logic        slow_mem = 1'b0;
    logic        tick = 1'b0;
    logic        pk_en = 1'b0;
    logic [9:0]  pk_idx = '0;
    logic [31:0] pk_val = '0;
    logic [31:0] mem [0:1023];
    int          dev_cnt = 0;

    int total = 0;
    int bad = 0;
    bit chk_on = 0;
    bit evt_m = 0;
    int exp_rd[$];
    logic [31:0] exp_wa[$];
    logic [7:0]  exp_wb[$];
    logic [7:0]  exp_tx[$];

    always #4 clk = ~clk;

    bmdma_engine i_bmdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .dev_req(dev_req), .dev_ack(dev_ack), .dev_rx_data(dev_rx_data),
        .dev_tx_data(dev_tx_data), .dev_intrq(dev_intrq)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] mbyte(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    assign mem_rdata   = mem[mem_addr[11:2]];
    assign mem_ready   = slow_mem ? tick : 1'b1;
    assign dev_rx_data = pat(dev_cnt);

    always @(posedge clk) begin
        tick <= ~tick;
        if (dev_req && dev_ack) dev_cnt <= dev_cnt + 1;
        if (pk_en) mem[pk_idx] <= pk_val;
        else if (mem_req && mem_we && mem_ready)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] v);
        reg_wr = 1'b1; reg_sel = sel; reg_be = be; reg_wdata = v;
        step();
        reg_wr = 1'b0; reg_sel = 1'b0; reg_be = 4'h0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        @(negedge clk); v = reg_rdata;
        step();
        reg_sel = 1'b0;
    endtask

    task automatic poke(input int widx, input logic [31:0] v);
        pk_en = 1'b1; pk_idx = 10'(widx); pk_val = v;
        step();
        pk_en = 1'b0;
    endtask

    task automatic put_desc(input int at, input logic [31:0] buf_a, input logic [15:0] cnt, input bit last);
        poke(at >> 2, buf_a);
        poke((at >> 2) + 1, {last, 15'h0, cnt});
    endtask

    task automatic wait_idle(input int lim);
        int n = 0;
        do begin
            @(negedge clk); n++;
        end while (reg_rdata[16] && n < lim);
        step();
    endtask

    task automatic monitor();
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (chk_on && mem_req && mem_ready && !mem_we) begin
                    if (exp_rd.size() == 0) chk(0, "R3 unexpected read", mem_addr, 0);
                    else begin
                        int ea = exp_rd.pop_front();
                        chk(mem_addr == 32'(ea), "R3 read address", mem_addr, 32'(ea));
                    end
                end
                if (chk_on && mem_req && mem_ready && mem_we) begin
                    if (exp_wa.size() == 0) chk(0, "R4 unexpected write", mem_addr, 0);
                    else begin
                        logic [31:0] wa = exp_wa.pop_front();
                        logic [7:0]  wb = exp_wb.pop_front();
                        chk(mem_addr == {wa[31:2], 2'b00}, "R4 write address", mem_addr, {wa[31:2], 2'b00});
                        chk(mem_be == (4'b0001 << wa[1:0]), "R4 write lane", 32'(mem_be), 32'(4'b0001 << wa[1:0]));
                        chk(mem_wdata[8*wa[1:0] +: 8] == wb, "R4 write byte", 32'(mem_wdata[8*wa[1:0] +: 8]), 32'(wb));
                    end
                end
                if (chk_on && dev_req && dev_ack && exp_tx.size() != 0) begin
                    logic [7:0] tb = exp_tx.pop_front();
                    chk(dev_tx_data == tb, "R5 device byte", 32'(dev_tx_data), 32'(tb));
                end
                // R9 per-clock model of the event bit
                if (!reg_sel) chk(reg_rdata[18] == evt_m, "R9 event model", 32'(reg_rdata[18]), 32'(evt_m));
                evt_m = dev_intrq || (evt_m && !(reg_wr && !reg_sel && reg_be[2] && reg_wdata[18]));
            end
        end
    endtask

    task automatic run_all();
        logic [31:0] v;
        int base;
        bit saw;

        // reset
        repeat (3) step();
        @(negedge clk);
        chk(mem_req == 1'b0 && dev_ack == 1'b0, "R1 idle outputs in reset", 32'({mem_req, dev_ack}), 0);
        rst_n = 1'b1;
        step();
        rd(1'b0, v); chk(v == 0, "R1 control dword after reset", v, 0);
        rd(1'b1, v); chk(v == 0, "R1 pointer after reset", v, 0);

        // R2 pointer alignment and byte lanes
        wr(1'b1, 4'hF, 32'h0000_0103);
        rd(1'b1, v); chk(v == 32'h100, "R2 pointer low bits", v, 32'h100);
        wr(1'b1, 4'b0010, 32'h0000_AB00);
        rd(1'b1, v); chk(v == 32'h0000_AB00, "R2 pointer byte lane", v, 32'h0000_AB00);

        // R3 R4 R7 two chained descriptors, device to memory
        put_desc(32'h100, 32'h203, 16'd3, 1'b0);
        put_desc(32'h108, 32'h301, 16'd2, 1'b1);
        wr(1'b1, 4'hF, 32'h100);
        wr(1'b0, 4'b0001, 32'h08);
        base = dev_cnt;
        exp_rd = '{32'h100, 32'h104, 32'h108, 32'h10C};
        for (int k = 0; k < 3; k++) begin exp_wa.push_back(32'h203 + k); exp_wb.push_back(pat(base + k)); end
        for (int k = 0; k < 2; k++) begin exp_wa.push_back(32'h301 + k); exp_wb.push_back(pat(base + 3 + k)); end
        chk_on = 1; dev_req = 1'b1;
        wr(1'b0, 4'b0001, 32'h09);
        @(negedge clk); chk(reg_rdata[16] == 1'b1, "R3 busy after run edge", 32'(reg_rdata[16]), 1);
        wait_idle(500);
        dev_req = 1'b0;
        chk(exp_rd.size() == 0 && exp_wa.size() == 0, "R7 all regions moved", 32'(exp_rd.size() + exp_wa.size()), 0);
        chk(reg_rdata[16] == 1'b0, "R7 busy clears at end", 32'(reg_rdata[16]), 0);
        chk(dev_cnt - base == 5, "R7 byte total", 32'(dev_cnt - base), 5);
        chk_on = 0;

        // R5 memory to device with memory wait states
        for (int w = 32'h3F0; w < 32'h3F8; w += 4)
            poke(w >> 2, {mbyte(w + 3), mbyte(w + 2), mbyte(w + 1), mbyte(w)});
        put_desc(32'h180, 32'h3F2, 16'd5, 1'b1);
        wr(1'b0, 4'b0001, 32'h00);
        wr(1'b1, 4'hF, 32'h180);
        exp_rd = '{32'h180, 32'h184};
        for (int k = 0; k < 5; k++) begin
            exp_rd.push_back((32'h3F2 + k) & ~32'h3);
            exp_tx.push_back(mbyte(32'h3F2 + k));
        end
        slow_mem = 1'b1; chk_on = 1; dev_req = 1'b1;
        wr(1'b0, 4'b0001, 32'h01);
        wait_idle(500);
        dev_req = 1'b0; slow_mem = 1'b0;
        chk(exp_rd.size() == 0 && exp_tx.size() == 0, "R5 all bytes delivered", 32'(exp_rd.size() + exp_tx.size()), 0);
        chk_on = 0;

        // R11 direction held, R8 stop
        put_desc(32'h1C0, 32'h800, 16'd100, 1'b1);
        wr(1'b0, 4'b0001, 32'h00);
        wr(1'b1, 4'hF, 32'h1C0);
        wr(1'b0, 4'b0001, 32'h08);
        dev_req = 1'b1;
        wr(1'b0, 4'b0001, 32'h09);
        repeat (6) step();
        wr(1'b0, 4'b0001, 32'h01);
        @(negedge clk);
        chk(reg_rdata[3] == 1'b0 && reg_rdata[16] == 1'b1, "R11 readback new dir while busy",
            32'({reg_rdata[3], reg_rdata[16]}), 1);
        saw = 0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            if (mem_req && mem_we) saw = 1;
        end
        chk(saw, "R11 transfer keeps writing memory", 32'(saw), 1);
        step();
        wr(1'b0, 4'b0001, 32'h00);
        @(negedge clk); chk(reg_rdata[16] == 1'b0, "R8 busy clears on stop", 32'(reg_rdata[16]), 0);
        saw = 0;
        for (int k = 0; k < 5; k++) begin
            if (k > 0) @(negedge clk);
            if (mem_req || dev_ack) saw = 1;
        end
        chk(!saw, "R8 no traffic after stop", 32'(saw), 0);
        step();
        dev_req = 1'b0;

        // R9 event bit, W1C, set beats clear
        dev_intrq = 1'b1; step(); dev_intrq = 1'b0;
        @(negedge clk);
        chk(reg_rdata[18] == 1'b1 && reg_rdata[17] == 1'b0, "R9 event set while idle",
            32'(reg_rdata[18:17]), 32'h2);
        step();
        wr(1'b0, 4'b0100, 32'h0000_0000);
        @(negedge clk); chk(reg_rdata[18] == 1'b1, "R9 writing 0 keeps event", 32'(reg_rdata[18]), 1);
        step();
        wr(1'b0, 4'b0100, 32'h0004_0000);
        @(negedge clk); chk(reg_rdata[18] == 1'b0, "R9 event cleared by 1", 32'(reg_rdata[18]), 0);
        step();
        dev_intrq = 1'b1;
        wr(1'b0, 4'b0100, 32'h0004_0000);
        dev_intrq = 1'b0;
        @(negedge clk); chk(reg_rdata[18] == 1'b1, "R9 set wins over clear", 32'(reg_rdata[18]), 1);
        step();
        wr(1'b0, 4'b0100, 32'h0004_0000);

        // R10 device ends early
        put_desc(32'h1E0, 32'h900, 16'd50, 1'b1);
        wr(1'b0, 4'b0001, 32'h00);
        wr(1'b1, 4'hF, 32'h1E0);
        wr(1'b0, 4'b0001, 32'h08);
        dev_req = 1'b1;
        wr(1'b0, 4'b0001, 32'h09);
        repeat (10) step();
        dev_intrq = 1'b1; step(); dev_intrq = 1'b0;
        @(negedge clk);
        chk(reg_rdata[18:16] == 3'b110, "R10 fault set and busy cleared", 32'(reg_rdata[18:16]), 32'h6);
        chk(mem_req == 1'b0 && dev_ack == 1'b0, "R10 traffic halted", 32'({mem_req, dev_ack}), 0);
        step();
        dev_req = 1'b0;
        wr(1'b0, 4'b0100, 32'h0006_0000);
        @(negedge clk); chk(reg_rdata[18:16] == 3'b000, "R9 fault and event cleared", 32'(reg_rdata[18:16]), 0);
        step();

        // R6 zero count means 65536 bytes
        put_desc(32'h140, 32'h0, 16'd0, 1'b1);
        wr(1'b0, 4'b0001, 32'h00);
        wr(1'b1, 4'hF, 32'h140);
        wr(1'b0, 4'b0001, 32'h08);
        base = dev_cnt;
        exp_rd = '{32'h140, 32'h144};
        for (int k = 0; k < 65536; k++) begin exp_wa.push_back(32'(k)); exp_wb.push_back(pat(base + k)); end
        chk_on = 1; dev_req = 1'b1;
        wr(1'b0, 4'b0001, 32'h09);
        wait_idle(140000);
        dev_req = 1'b0;
        chk(exp_wa.size() == 0, "R6 zero count moved 65536 bytes", 32'(exp_wa.size()), 0);
        chk(dev_cnt - base == 65536, "R6 device byte total", 32'(dev_cnt - base), 32'd65536);
        chk_on = 0;
    endtask

    initial begin
        fork
            monitor();
            begin
                repeat (195000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog expired actual=hung expected=done");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
        run_all();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule